// File: doc/BRIEF.md
# Asynchronous HDLC Framer and Deframer

This block turns frames into a byte-stuffed HDLC stream for an asynchronous serial link, and turns that stream back into frames. It sits between a byte-wide UART datapath and the transmit and receive byte FIFOs. The serialiser, the baud generator and any infrared encoding are outside the block.

On transmit, the host writes a complete frame into the transmit FIFO before sending starts. The last byte of the frame is marked. The framer sends an opening flag, then the payload with the control octets escaped, then a 16-bit frame check sequence, and then a closing flag. On receive, the deframer finds frames between flags and removes the escapes. It can drop frames addressed to another station, and it checks the frame check sequence. Payload bytes go into the receive FIFO, followed by one end-of-frame status beat. As a configurable option, the two received check bytes are also passed through to the host.

Top module: `hdlc_codec`

## Requirements
- R1: A transmitted frame appears on the serial output in this order: flag 0x7E, the stuffed payload, the stuffed check sequence with its low byte first, and a closing flag 0x7E.
- R2: Any payload or check-sequence byte equal to 0x7E or 0x7D is sent as 0x7D followed by that byte XOR 0x20. All other bytes are sent unchanged.
- R3: The check sequence is the ones-complement of a CRC-16 over the payload. The CRC uses reflected polynomial 0x8408, is preset to 0xFFFF, and takes each byte least significant bit first.
- R4: While the serial output is valid but not accepted, its byte and valid stay unchanged. A transmit FIFO byte is popped only in a cycle in which a serial byte is accepted. Each payload byte is popped exactly once.
- R5: Received bytes before the first flag are discarded. Inside a frame, 0x7D is removed and the following byte is XORed with 0x20. Payload beats carry eof=0 and keep their order. The closing flag produces one status beat with eof=1 and a status code in the data field. The status code uses bit 0 for a check-sequence error, bit 1 for a short frame and bit 2 for an escape just before the flag. err is the OR of these three bits.
- R6: The CRC runs over all unescaped bytes of a frame, including the two check bytes. Status bit 0 is set when the result differs from the residue 0xF0B8.
- R7: When check bytes go to the host, every unescaped byte, including both check bytes, is delivered before the status beat. Otherwise the last two unescaped bytes of each frame are withheld.
- R8: When address matching is enabled, a frame is delivered only if its first unescaped byte equals the station address or 0xFF. Any other frame produces no beat at all, including no status beat. When matching is disabled, every frame is delivered.
- R9: A frame with fewer than 4 unescaped bytes sets status bit 1. Consecutive flags with nothing between them produce no beat.
- R10: If a frame ends with 0x7D directly followed by the flag, status bit 2 is set.
- R11: In reset and on the first cycle after it, no receive beat, no serial transmit byte and no FIFO pop is signalled.
- R12: Each receive beat appears on the cycle after the received byte that caused it. Each received byte causes at most one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr_match_en | input | 1 | Enable station address filtering on receive |
| cfg_station_addr | input | 8 | Station address accepted besides 0xFF |
| cfg_fcs_to_host | input | 1 | Deliver received check bytes to the receive FIFO |
| tx_fifo_valid | input | 1 | Transmit FIFO holds a byte |
| tx_fifo_data | input | 8 | Head byte of the transmit FIFO |
| tx_fifo_last | input | 1 | Head byte is the last byte of its frame |
| tx_fifo_pop | output | 1 | Head byte consumed this cycle |
| ser_tx_valid | output | 1 | Byte offered to the UART transmitter |
| ser_tx_data | output | 8 | Line byte to transmit |
| ser_tx_ready | input | 1 | UART transmitter accepts the byte |
| ser_rx_valid | input | 1 | UART receiver delivers a byte this cycle |
| ser_rx_data | input | 8 | Received line byte |
| rx_fifo_push | output | 1 | Beat written to the receive FIFO |
| rx_fifo_data | output | 8 | Payload byte, or the status code when eof is set |
| rx_fifo_eof | output | 1 | Beat is the end-of-frame status |
| rx_fifo_err | output | 1 | Status beat reports an error |

## Verification
A stuck escape-pending state in the deframer corrupts the next unescaped byte. It also sets the abort bit in the status beat one cycle after the closing flag. A check register that missed a byte shows up two ways. On receive, a good frame is reported with a check error. On transmit, the two check bytes on the line are wrong right before the closing flag. A wrong hold count in the deframer adds or removes payload beats before the status beat. A framer state that skips or repeats a step changes the byte sequence on the line, or the number of FIFO pops, within the same frame.

// File: rtl/hdlc_pkg.sv
package hdlc_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] FLAG_OCTET  = 8'h7E;
    localparam logic [BYTE_W-1:0] ESC_OCTET   = 8'h7D;
    localparam logic [BYTE_W-1:0] ESC_FLIP    = 8'h20;
    localparam logic [BYTE_W-1:0] ALL_STATION = 8'hFF;

    localparam int FCS_W     = 16;
    localparam int FCS_BYTES = FCS_W / BYTE_W;
    localparam logic [FCS_W-1:0] FCS_INIT    = 16'hFFFF;
    localparam logic [FCS_W-1:0] FCS_POLY    = 16'h8408;
    localparam logic [FCS_W-1:0] FCS_RESIDUE = 16'hF0B8;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_OPEN,
        TX_BODY,
        TX_BODY_ESC,
        TX_FCS,
        TX_FCS_ESC,
        TX_CLOSE
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_FRAME,
        RX_DROP
    } rx_state_e;

    // packed from msb: bit 2 abort, bit 1 short, bit 0 check error
    typedef struct packed {
        logic abort;
        logic too_short;
        logic fcs_bad;
    } rx_status_t;

    localparam int STATUS_W = $bits(rx_status_t);

    function automatic logic is_control(input logic [BYTE_W-1:0] b);
        return (b == FLAG_OCTET) || (b == ESC_OCTET);
    endfunction

    function automatic logic [FCS_W-1:0] fcs_step(input logic [FCS_W-1:0] c,
                                                  input logic [BYTE_W-1:0] b);
        logic [FCS_W-1:0] r;
        r = c ^ {{(FCS_W-BYTE_W){1'b0}}, b};
        for (int i = 0; i < BYTE_W; i++) begin
            r = r[0] ? ((r >> 1) ^ FCS_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    input  logic [BYTE_W-1:0] src_data,
    input  logic              src_last,
    output logic              src_ready,
    output logic              line_valid,
    output logic [BYTE_W-1:0] line_data,
    input  logic              line_ready
);

    localparam int IDX_W = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FCS_BYTES - 1);

    tx_state_e         state;
    logic [FCS_W-1:0]  fcs;
    logic [BYTE_W-1:0] hold;
    logic              last_r;
    logic [IDX_W-1:0]  fcs_idx;

    logic [FCS_W-1:0]  fcs_final;
    logic [BYTE_W-1:0] fcs_byte;

    assign fcs_final = ~fcs;
    assign fcs_byte  = fcs_final[fcs_idx*BYTE_W +: BYTE_W];

    always_comb begin
        line_valid = 1'b0;
        line_data  = '0;
        src_ready  = 1'b0;
        case (state)
            TX_OPEN, TX_CLOSE: begin
                line_valid = 1'b1;
                line_data  = FLAG_OCTET;
            end
            TX_BODY: begin
                line_valid = src_valid;
                line_data  = is_control(src_data) ? ESC_OCTET : src_data;
                src_ready  = src_valid && line_ready;
            end
            TX_BODY_ESC, TX_FCS_ESC: begin
                line_valid = 1'b1;
                line_data  = hold;
            end
            TX_FCS: begin
                line_valid = 1'b1;
                line_data  = is_control(fcs_byte) ? ESC_OCTET : fcs_byte;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TX_IDLE;
            fcs     <= FCS_INIT;
            hold    <= '0;
            last_r  <= 1'b0;
            fcs_idx <= '0;
        end else begin
            case (state)
                TX_IDLE: begin
                    fcs     <= FCS_INIT;
                    fcs_idx <= '0;
                    if (src_valid) state <= TX_OPEN;
                end
                TX_OPEN: if (line_ready) state <= TX_BODY;
                TX_BODY: if (src_valid && line_ready) begin
                    fcs <= fcs_step(fcs, src_data);
                    if (is_control(src_data)) begin
                        hold   <= src_data ^ ESC_FLIP;
                        last_r <= src_last;
                        state  <= TX_BODY_ESC;
                    end else if (src_last) begin
                        state <= TX_FCS;
                    end
                end
                TX_BODY_ESC: if (line_ready) state <= last_r ? TX_FCS : TX_BODY;
                TX_FCS: if (line_ready) begin
                    if (is_control(fcs_byte)) begin
                        hold  <= fcs_byte ^ ESC_FLIP;
                        state <= TX_FCS_ESC;
                    end else if (fcs_idx == IDX_LAST) begin
                        state <= TX_CLOSE;
                    end else begin
                        fcs_idx <= fcs_idx + 1'b1;
                    end
                end
                TX_FCS_ESC: if (line_ready) begin
                    if (fcs_idx == IDX_LAST) begin
                        state <= TX_CLOSE;
                    end else begin
                        fcs_idx <= fcs_idx + 1'b1;
                        state   <= TX_FCS;
                    end
                end
                TX_CLOSE: if (line_ready) state <= TX_IDLE;
                default: state <= TX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_pkg::*;
#(
    parameter int MIN_FRAME_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              addr_en,
    input  logic [BYTE_W-1:0] addr,
    input  logic              fcs_pass,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_eof,
    output logic              out_err
);

    localparam int CNT_W  = $clog2(MIN_FRAME_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MIN_FRAME_LEN);
    localparam int HOLD_W = $clog2(FCS_BYTES + 1);
    localparam logic [HOLD_W-1:0] HOLD_FULL = HOLD_W'(FCS_BYTES);

    rx_state_e                         state;
    logic                              esc_pend;
    logic [CNT_W-1:0]                  cnt;
    logic [FCS_W-1:0]                  fcs;
    logic [FCS_BYTES-1:0][BYTE_W-1:0]  hold;
    logic [HOLD_W-1:0]                 hold_cnt;

    logic [BYTE_W-1:0] decoded;
    logic [FCS_W-1:0]  fcs_next;
    logic              addr_ok;
    rx_status_t        status;

    assign decoded  = esc_pend ? (byte_data ^ ESC_FLIP) : byte_data;
    assign fcs_next = fcs_step(fcs, decoded);
    assign addr_ok  = !addr_en || (decoded == addr) || (decoded == ALL_STATION);

    always_comb begin
        status.fcs_bad   = (fcs != FCS_RESIDUE);
        status.too_short = (cnt < CNT_SAT);
        status.abort     = esc_pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_HUNT;
            esc_pend  <= 1'b0;
            cnt       <= '0;
            fcs       <= FCS_INIT;
            hold      <= '0;
            hold_cnt  <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_eof   <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_eof   <= 1'b0;
            out_err   <= 1'b0;
            if (byte_valid) begin
                if (byte_data == FLAG_OCTET && !(state == RX_FRAME && esc_pend == 1'b0
                                                 && cnt == '0)) begin
                    if (state == RX_FRAME) begin
                        out_valid <= 1'b1;
                        out_eof   <= 1'b1;
                        out_err   <= |status;
                        out_data  <= {{(BYTE_W-STATUS_W){1'b0}}, status};
                    end
                    state    <= RX_FRAME;
                    esc_pend <= 1'b0;
                    cnt      <= '0;
                    fcs      <= FCS_INIT;
                    hold_cnt <= '0;
                end else if (state == RX_FRAME && byte_data != FLAG_OCTET) begin
                    if (byte_data == ESC_OCTET && !esc_pend) begin
                        esc_pend <= 1'b1;
                    end else begin
                        esc_pend <= 1'b0;
                        fcs      <= fcs_next;
                        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
                        if (cnt == '0 && !addr_ok) begin
                            state <= RX_DROP;
                        end else if (fcs_pass) begin
                            out_valid <= 1'b1;
                            out_data  <= decoded;
                        end else begin
                            hold[0] <= decoded;
                            for (int i = 1; i < FCS_BYTES; i++) begin
                                hold[i] <= hold[i-1];
                            end
                            if (hold_cnt == HOLD_FULL) begin
                                out_valid <= 1'b1;
                                out_data  <= hold[FCS_BYTES-1];
                            end else begin
                                hold_cnt <= hold_cnt + 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/hdlc_codec.sv
module hdlc_codec
    import hdlc_pkg::*;
#(
    parameter int MIN_FRAME_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_addr_match_en,
    input  logic [7:0] cfg_station_addr,
    input  logic       cfg_fcs_to_host,
    input  logic       tx_fifo_valid,
    input  logic [7:0] tx_fifo_data,
    input  logic       tx_fifo_last,
    output logic       tx_fifo_pop,
    output logic       ser_tx_valid,
    output logic [7:0] ser_tx_data,
    input  logic       ser_tx_ready,
    input  logic       ser_rx_valid,
    input  logic [7:0] ser_rx_data,
    output logic       rx_fifo_push,
    output logic [7:0] rx_fifo_data,
    output logic       rx_fifo_eof,
    output logic       rx_fifo_err
);

    hdlc_tx_framer u_tx (
        .clk        (clk),
        .rst        (rst),
        .src_valid  (tx_fifo_valid),
        .src_data   (tx_fifo_data),
        .src_last   (tx_fifo_last),
        .src_ready  (tx_fifo_pop),
        .line_valid (ser_tx_valid),
        .line_data  (ser_tx_data),
        .line_ready (ser_tx_ready)
    );

    hdlc_rx_deframer #(
        .MIN_FRAME_LEN (MIN_FRAME_LEN)
    ) u_rx (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (ser_rx_valid),
        .byte_data  (ser_rx_data),
        .addr_en    (cfg_addr_match_en),
        .addr       (cfg_station_addr),
        .fcs_pass   (cfg_fcs_to_host),
        .out_valid  (rx_fifo_push),
        .out_data   (rx_fifo_data),
        .out_eof    (rx_fifo_eof),
        .out_err    (rx_fifo_err)
    );

endmodule

// File: rtl/hdlc_codec_checker.sv
module hdlc_codec_checker
    import hdlc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tx_fifo_pop,
    input logic       ser_tx_valid,
    input logic [7:0] ser_tx_data,
    input logic       ser_tx_ready,
    input logic       ser_rx_valid,
    input logic [7:0] ser_rx_data,
    input logic       rx_fifo_push,
    input logic       rx_fifo_eof,
    input logic       rx_fifo_err
);

    assert_tx_hold_R4: assert property (@(posedge clk) disable iff (rst)
        ser_tx_valid && !ser_tx_ready |=> ser_tx_valid && $stable(ser_tx_data));

    assert_tx_pop_R4: assert property (@(posedge clk) disable iff (rst)
        tx_fifo_pop |-> ser_tx_valid && ser_tx_ready);

    assert_tx_escape_R2: assert property (@(posedge clk) disable iff (rst)
        ser_tx_valid && ser_tx_ready && ser_tx_data == ESC_OCTET
        |=> ser_tx_valid && (ser_tx_data == (FLAG_OCTET ^ ESC_FLIP)
                          || ser_tx_data == (ESC_OCTET ^ ESC_FLIP)));

    assert_rx_flag_status_R5: assert property (@(posedge clk) disable iff (rst)
        ser_rx_valid && ser_rx_data == FLAG_OCTET |=> !rx_fifo_push || rx_fifo_eof);

    assert_rx_err_on_eof_R5: assert property (@(posedge clk) disable iff (rst)
        rx_fifo_err |-> rx_fifo_push && rx_fifo_eof);

    assert_rx_latency_R12: assert property (@(posedge clk) disable iff (rst)
        rx_fifo_push |-> $past(ser_rx_valid));

    assert_reset_idle_R11: assert property (@(posedge clk)
        $past(rst) |-> !rx_fifo_push && !ser_tx_valid && !tx_fifo_pop);

endmodule

bind hdlc_codec hdlc_codec_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_fifo_pop  (tx_fifo_pop),
    .ser_tx_valid (ser_tx_valid),
    .ser_tx_data  (ser_tx_data),
    .ser_tx_ready (ser_tx_ready),
    .ser_rx_valid (ser_rx_valid),
    .ser_rx_data  (ser_rx_data),
    .rx_fifo_push (rx_fifo_push),
    .rx_fifo_eof  (rx_fifo_eof),
    .rx_fifo_err  (rx_fifo_err)
);

// File: tb/tb_hdlc_codec.sv
module tb_hdlc_codec;

    typedef logic [7:0] bytes_t [$];

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_addr_match_en, cfg_fcs_to_host;
    logic [7:0] cfg_station_addr;
    logic       tx_fifo_valid, tx_fifo_last, tx_fifo_pop;
    logic [7:0] tx_fifo_data;
    logic       ser_tx_valid, ser_tx_ready;
    logic [7:0] ser_tx_data;
    logic       ser_rx_valid;
    logic [7:0] ser_rx_data;
    logic       rx_fifo_push, rx_fifo_eof, rx_fifo_err;
    logic [7:0] rx_fifo_data;

    always #5 clk = ~clk;

    hdlc_codec dut (.*);

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [9:0] rx_got[$];
    int         rx_got_cyc[$];
    logic [9:0] rx_exp[$];
    int         sent_cyc[$];

    always @(negedge clk) begin
        if (!rst && rx_fifo_push) begin
            rx_got.push_back({rx_fifo_err, rx_fifo_eof, rx_fifo_data});
            rx_got_cyc.push_back(cyc);
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_bits(input logic [15:0] c, input logic [7:0] d);
        logic fb;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ d[i];
            c  = c >> 1;
            if (fb) c = c ^ 16'h8408;
        end
        return c;
    endfunction

    function automatic bytes_t add_fcs(input bytes_t p);
        bytes_t r;
        logic [15:0] c;
        c = 16'hFFFF;
        foreach (p[i]) begin
            c = crc_bits(c, p[i]);
            r.push_back(p[i]);
        end
        c = ~c;
        r.push_back(c[7:0]);
        r.push_back(c[15:8]);
        return r;
    endfunction

    function automatic bytes_t stuff(input bytes_t p);
        bytes_t r;
        foreach (p[i]) begin
            if (p[i] == 8'h7E || p[i] == 8'h7D) begin
                r.push_back(8'h7D);
                r.push_back(p[i] ^ 8'h20);
            end else begin
                r.push_back(p[i]);
            end
        end
        return r;
    endfunction

    function automatic bytes_t on_line(input bytes_t decoded);
        bytes_t r;
        bytes_t s;
        s = stuff(decoded);
        r.push_back(8'h7E);
        foreach (s[i]) r.push_back(s[i]);
        r.push_back(8'h7E);
        return r;
    endfunction

    // expected receive beats from the requirements (R5..R10)
    function automatic void model_rx(input bytes_t d, input bit abort);
        logic [15:0] c;
        logic [2:0]  st;
        int n;
        n = d.size();
        if (n == 0 && !abort) return;
        if (cfg_addr_match_en && n > 0 && d[0] != cfg_station_addr && d[0] != 8'hFF) return;
        if (cfg_fcs_to_host) begin
            foreach (d[i]) rx_exp.push_back({2'b00, d[i]});
        end else begin
            for (int i = 0; i < n - 2; i++) rx_exp.push_back({2'b00, d[i]});
        end
        c = 16'hFFFF;
        foreach (d[i]) c = crc_bits(c, d[i]);
        st = {abort, (n < 4), (c != 16'hF0B8)};
        rx_exp.push_back({|st, 1'b1, 5'b0, st});
    endfunction

    task automatic send_line(input bytes_t line, input int gap);
        foreach (line[i]) begin
            @(negedge clk);
            ser_rx_valid = 1'b1;
            ser_rx_data  = line[i];
            sent_cyc.push_back(cyc);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                ser_rx_valid = 1'b0;
            end
        end
        @(negedge clk);
        ser_rx_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic compare_rx(input string req);
        check(rx_got.size() == rx_exp.size(), req, rx_got.size(), rx_exp.size());
        foreach (rx_exp[i]) begin
            if (i < rx_got.size()) check(rx_got[i] == rx_exp[i], req, rx_got[i], rx_exp[i]);
        end
    endtask

    task automatic rx_case(input string req, input bytes_t line, input bytes_t decoded,
                           input bit abort, input int gap);
        rx_got.delete(); rx_got_cyc.delete(); rx_exp.delete(); sent_cyc.delete();
        model_rx(decoded, abort);
        send_line(line, gap);
        compare_rx(req);
    endtask

    task automatic tx_case(input string req, input bytes_t payload, input int stall_mod);
        bytes_t got;
        bytes_t exp;
        int     idx = 0;
        int     flags = 0;
        bit     prev_stall = 0;
        logic [7:0] prev_data = '0;
        bit     stable_ok = 1;
        exp = on_line(add_fcs(payload));
        for (int k = 0; k < 2000 && flags < 2; k++) begin
            @(negedge clk);
            tx_fifo_valid = (idx < payload.size());
            tx_fifo_data  = (idx < payload.size()) ? payload[idx] : 8'h00;
            tx_fifo_last  = (idx == payload.size() - 1);
            ser_tx_ready  = (stall_mod == 0) ? 1'b1 : ((k % stall_mod) != 0);
            #1;
            if (prev_stall && !(ser_tx_valid && ser_tx_data == prev_data)) stable_ok = 0;
            prev_stall = ser_tx_valid && !ser_tx_ready;
            prev_data  = ser_tx_data;
            if (ser_tx_valid && ser_tx_ready) begin
                got.push_back(ser_tx_data);
                if (ser_tx_data == 8'h7E) flags++;
            end
            if (tx_fifo_pop) idx++;
        end
        @(negedge clk);
        tx_fifo_valid = 1'b0;
        ser_tx_ready  = 1'b1;
        check(got.size() == exp.size(), {req, " length"}, got.size(), exp.size());
        foreach (exp[i]) begin
            if (i < got.size()) check(got[i] == exp[i], req, got[i], exp[i]);
        end
        check(idx == payload.size(), "R4 pop count", idx, payload.size());
        check(stable_ok, "R4 hold under stall", stable_ok, 1);
    endtask

    task automatic test_reset_R11;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!rx_fifo_push && !ser_tx_valid && !tx_fifo_pop, "R11 reset outputs",
              {rx_fifo_push, ser_tx_valid, tx_fifo_pop}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!rx_fifo_push && !ser_tx_valid && !tx_fifo_pop, "R11 after reset",
              {rx_fifo_push, ser_tx_valid, tx_fifo_pop}, 0);
    endtask

    task automatic test_tx_plain_R1_R3;
        tx_case("R1 R3 plain frame", '{8'hFF, 8'h03, 8'h11, 8'h22}, 0);
    endtask

    task automatic test_tx_escape_R2;
        bytes_t p;
        bytes_t f;
        bit found = 0;
        tx_case("R2 payload escape with stall", '{8'hFF, 8'h7E, 8'h03, 8'h7D, 8'h55}, 3);
        for (int v = 0; v < 256 && !found; v++) begin
            p = '{8'h10, 8'(v)};
            f = add_fcs(p);
            if (f[2] == 8'h7E || f[2] == 8'h7D || f[3] == 8'h7E || f[3] == 8'h7D) found = 1;
        end
        check(found, "R2 check-byte escape case exists", found, 1);
        if (found) tx_case("R2 R3 escaped check byte", p, 2);
    endtask

    task automatic test_rx_basic_R5_R6;
        bytes_t d;
        bytes_t line;
        cfg_addr_match_en = 0; cfg_fcs_to_host = 0;
        d = add_fcs('{8'h01, 8'h03, 8'hA5, 8'h5A});
        line = on_line(d);
        line.push_front(8'h22);
        line.push_front(8'h11);
        rx_case("R5 R6 good frame after noise", line, d, 0, 2);
    endtask

    task automatic test_rx_pass_R7;
        bytes_t d;
        cfg_fcs_to_host = 1;
        d = add_fcs('{8'h01, 8'h03, 8'hA5, 8'h5A});
        rx_case("R7 check bytes to host", on_line(d), d, 0, 1);
        cfg_fcs_to_host = 0;
    endtask

    task automatic test_rx_badfcs_R6;
        bytes_t d;
        d = add_fcs('{8'h01, 8'h03, 8'h44});
        d[d.size()-1] = d[d.size()-1] ^ 8'h01;
        rx_case("R6 bad check sequence", on_line(d), d, 0, 1);
    endtask

    task automatic test_rx_addr_R8;
        bytes_t d;
        cfg_addr_match_en = 1; cfg_station_addr = 8'h21;
        d = add_fcs('{8'h30, 8'h03, 8'h99});
        rx_case("R8 foreign address dropped", on_line(d), d, 0, 1);
        check(rx_got.size() == 0, "R8 nothing delivered", rx_got.size(), 0);
        d = add_fcs('{8'hFF, 8'h03, 8'h99});
        rx_case("R8 all-station address", on_line(d), d, 0, 1);
        d = add_fcs('{8'h21, 8'h13, 8'h77});
        rx_case("R8 own address", on_line(d), d, 0, 1);
        cfg_addr_match_en = 0;
        d = add_fcs('{8'h30, 8'h03, 8'h99});
        rx_case("R8 filter disabled", on_line(d), d, 0, 1);
    endtask

    task automatic test_rx_short_R9;
        bytes_t d;
        bytes_t line;
        bytes_t none;
        rx_case("R9 empty flags", '{8'h7E, 8'h7E, 8'h7E}, none, 0, 1);
        d = add_fcs('{8'h05});
        line = on_line(d);
        rx_case("R9 short frame", line, d, 0, 1);
    endtask

    task automatic test_rx_abort_R10;
        bytes_t d;
        d = '{8'h01, 8'h02, 8'h03, 8'h04};
        rx_case("R10 escape before flag",
                '{8'h7E, 8'h01, 8'h02, 8'h03, 8'h04, 8'h7D, 8'h7E}, d, 1, 1);
    endtask

    task automatic test_rx_timing_R12;
        bytes_t d;
        bytes_t line;
        int last;
        cfg_fcs_to_host = 1;
        d = add_fcs('{8'h03, 8'h7E, 8'h7D, 8'h20});
        line = on_line(d);
        rx_case("R5 R12 unescape back-to-back", line, d, 0, 0);
        last = sent_cyc.size() - 1;
        if (rx_got_cyc.size() > 0) begin
            check(rx_got_cyc[0] == sent_cyc[1] + 1, "R12 first beat latency",
                  rx_got_cyc[0], sent_cyc[1] + 1);
            check(rx_got_cyc[rx_got_cyc.size()-1] == sent_cyc[last] + 1,
                  "R12 status beat latency", rx_got_cyc[rx_got_cyc.size()-1], sent_cyc[last] + 1);
        end else begin
            check(0, "R12 beats present", 0, 1);
        end
        cfg_fcs_to_host = 0;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        cfg_addr_match_en = 0; cfg_station_addr = 8'h00; cfg_fcs_to_host = 0;
        tx_fifo_valid = 0; tx_fifo_data = 0; tx_fifo_last = 0; ser_tx_ready = 1;
        ser_rx_valid = 0; ser_rx_data = 0;
        test_reset_R11();
        test_tx_plain_R1_R3();
        test_tx_escape_R2();
        test_rx_basic_R5_R6();
        test_rx_pass_R7();
        test_rx_badfcs_R6();
        test_rx_addr_R8();
        test_rx_short_R9();
        test_rx_abort_R10();
        test_rx_timing_R12();
        finish_run();
    end

endmodule